// File: doc/BRIEF.md
# Direct-Mapped Write-Through Snooping Bus Cache

This block is a small cache that listens on a shared processor-to-memory bus. It keeps copies of single data words it has seen go by. When the processor starts a read whose word the cache holds, the cache answers itself. It drives the stored word, raises its share of the wired-OR acknowledge line and raises a preempt signal so that slow memory can abandon the cycle. On a read miss the cache stays silent. When memory acknowledges, the cache captures the returned word. Writes always complete in memory, and the cache records the written word at the moment memory acknowledges it.

The store is direct-mapped and holds one word per entry. The low `INDEX_W` bits of the word address select the entry. The remaining upper bits are kept as that entry's tag, next to a valid bit and the data word. With `INDEX_W = 15` and a 30-bit address, the store has 32K entries and 15-bit tags. The default of 8 keeps elaboration small. A flush input clears every valid bit in one cycle, for use when the address mapping changes. An uncached input marks a device-register cycle: that cycle neither hits nor fills. An uncached write whose tag matches the indexed entry invalidates that entry, so no stale copy survives.

Bus cycles are tracked by a controller with five states:
- `ST_IDLE`: no cycle in progress.
- `ST_HIT`: the cache is answering a read.
- `ST_MISS`: a read is waiting for memory.
- `ST_WRITE`: a write is waiting for memory.
- `ST_DRAIN`: memory has answered and the controller waits for the strobes to drop.

The transitions are:
- IDLE→WRITE when write is sampled. Write wins over read.
- IDLE→HIT on a read that is cacheable, valid and whose tag matches.
- IDLE→MISS on any other read.
- HIT→IDLE when read drops or write appears.
- MISS→DRAIN or WRITE→DRAIN on memory ack, with capture in that cycle.
- MISS→IDLE or WRITE→IDLE when the strobe drops before ack. This is an aborted cycle with no capture.
- DRAIN→IDLE once both strobes are low.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset every entry is invalid. A read to any address then gets no cache ack. While the cache does not drive, `bus_data_oe` is 0 and `bus_data_out` is 0.
- R2: A cacheable read whose address matches a valid entry (equal index and tag) raises `ack_drive` and `bus_data_oe` after the first rising edge that samples `bus_rd` high. At the same time `bus_data_out` shows the stored word, and this holds while `bus_rd` stays high.
- R3: On a cacheable read miss, the word on `bus_data_in` in the cycle memory raises `mem_ack` is stored with the address tag. A later read of that address hits with that word.
- R4: A cacheable write stores `bus_data_in` and the tag when `mem_ack` arrives, so later reads hit with the written word. The cache never raises `ack_drive` in a write cycle.
- R5: A read whose index matches a valid entry but whose upper address bits differ is a miss. Its fill replaces the old entry, and the old address then misses.
- R6: A one-cycle `flush` pulse invalidates all entries, so previously cached addresses miss.
- R7: With `uncached` high during a read, the cache gives no ack even for a matching entry and does not fill from memory's data.
- R8: An uncached write does not fill. If the indexed entry holds the same tag, that entry becomes invalid.
- R9: `preempt` and `bus_data_oe` are high exactly when `ack_drive` is high.
- R10: `ack_drive` falls after the first rising edge that samples `bus_rd` low.
- R11: A read miss whose `bus_rd` drops before `mem_ack` stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid bits |
| flush | input | 1 | Invalidate every entry |
| uncached | input | 1 | Current cycle must neither hit nor fill |
| bus_addr | input | ADDR_W | Word address on the bus |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_data_in | input | DATA_W | Data seen on the bus |
| mem_ack | input | 1 | Memory's acknowledge |
| bus_data_out | output | DATA_W | Word the cache drives on a hit |
| bus_data_oe | output | 1 | Enable for the cache's data driver |
| ack_drive | output | 1 | Cache's contribution to the wired-OR ack |
| preempt | output | 1 | Tells memory to abandon the current read |

## Verification
A hit answer (ack, preempt, enable and data) is due one rising edge after read is first sampled. It falls one edge after read is sampled low. A fill or write capture happens on the edge that samples `mem_ack`, so it shows on the next read that begins after it. The bench drives every input on the falling edge and samples on the following falling edge, half a period after the edge that must have produced the value. A behavioural array model predicts hit or miss for each access from the stored valid, tag and data values.

// File: rtl/snc_pkg.sv
package snc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HIT   = 3'd1,
        ST_MISS  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DRAIN = 3'd4
    } cyc_state_e;

endpackage

// File: rtl/snc_store.sv
module snc_store #(
    parameter int ADDR_W  = 30,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    input  logic              cap_en,
    input  logic              kill_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int DEPTH = 1 << INDEX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    logic [INDEX_W-1:0] l_idx, c_idx;
    logic [TAG_W-1:0]   l_tag, c_tag;

    assign l_idx = look_addr[INDEX_W-1:0];
    assign l_tag = look_addr[ADDR_W-1:INDEX_W];
    assign c_idx = cap_addr[INDEX_W-1:0];
    assign c_tag = cap_addr[ADDR_W-1:INDEX_W];

    // Valid bits: reset and flush win over any capture in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (cap_en) begin
            valid_q[c_idx] <= 1'b1;
        end else if (kill_en && (tag_q[c_idx] == c_tag)) begin
            valid_q[c_idx] <= 1'b0;
        end
    end

    // Tag and data arrays need no reset; the valid bit guards them.
    always_ff @(posedge clk) begin
        if (cap_en) begin
            tag_q[c_idx]  <= c_tag;
            data_q[c_idx] <= cap_data;
        end
    end

    assign look_hit  = valid_q[l_idx] && (tag_q[l_idx] == l_tag);
    assign look_data = data_q[l_idx];

    // R6: a flush leaves every entry invalid on the following cycle
    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
    import snc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic mem_ack,
    input  logic uncached,
    input  logic look_hit,
    output logic start,
    output logic load_out,
    output logic cap_en,
    output logic kill_en,
    output logic ack_out
);
    cyc_state_e state_q, state_d;
    logic       unc_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_wr)
                    state_d = ST_WRITE;
                else if (bus_rd)
                    state_d = (look_hit && !uncached) ? ST_HIT : ST_MISS;
            end
            ST_HIT: begin
                if (!bus_rd || bus_wr)
                    state_d = ST_IDLE;
            end
            ST_MISS: begin
                if (!bus_rd)
                    state_d = ST_IDLE;
                else if (mem_ack)
                    state_d = ST_DRAIN;
            end
            ST_WRITE: begin
                if (!bus_wr)
                    state_d = ST_IDLE;
                else if (mem_ack)
                    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!bus_rd && !bus_wr)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and latched cycle attribute
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            unc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start)
                unc_q <= uncached;
        end
    end

    // Outputs
    always_comb begin
        start    = 1'b0;
        load_out = 1'b0;
        cap_en   = 1'b0;
        kill_en  = 1'b0;
        ack_out  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start    = bus_rd || bus_wr;
                load_out = bus_rd && !bus_wr && look_hit && !uncached;
            end
            ST_HIT:   ack_out = 1'b1;
            ST_MISS:  cap_en  = bus_rd && mem_ack && !unc_q;
            ST_WRITE: begin
                cap_en  = bus_wr && mem_ack && !unc_q;
                kill_en = bus_wr && mem_ack && unc_q;
            end
            ST_DRAIN: ;
            default: ;
        endcase
    end

    // R2: the cache only answers a read that was on the bus one edge earlier
    p_ack_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |-> $past(bus_rd));

    // R10: once read is sampled low the ack is gone after that edge
    p_ack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !ack_out);

    // R4: a write cycle never sees the cache acknowledge
    p_no_ack_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd) |=> !ack_out);

    // R7: an uncached read started from idle is never answered
    p_uncached_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bus_rd && !bus_wr && uncached) |=> !ack_out);

    // R3: the store only captures while memory acknowledges
    p_capture_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en || kill_en) |-> mem_ack);

endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
    parameter int ADDR_W  = 30,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              uncached,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              mem_ack,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic              ack_drive,
    output logic              preempt
);
    logic              start, load_out, cap_en, kill_en, ack_out;
    logic              look_hit;
    logic [DATA_W-1:0] look_data;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] hold_q;

    snc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .mem_ack  (mem_ack),
        .uncached (uncached),
        .look_hit (look_hit),
        .start    (start),
        .load_out (load_out),
        .cap_en   (cap_en),
        .kill_en  (kill_en),
        .ack_out  (ack_out)
    );

    snc_store #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .INDEX_W (INDEX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .look_addr (bus_addr),
        .look_hit  (look_hit),
        .look_data (look_data),
        .cap_en    (cap_en),
        .kill_en   (kill_en),
        .cap_addr  (addr_q),
        .cap_data  (bus_data_in)
    );

    // Cycle address and the word returned on a hit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            hold_q <= '0;
        end else begin
            if (start)
                addr_q <= bus_addr;
            if (load_out)
                hold_q <= look_data;
        end
    end

    assign ack_drive    = ack_out;
    assign preempt      = ack_out;
    assign bus_data_oe  = ack_out;
    assign bus_data_out = ack_out ? hold_q : '0;

endmodule

// File: tb/snoop_wt_cache_bench.sv
module snoop_wt_cache_bench;
    localparam int AW = 30;
    localparam int DW = 32;
    localparam int IW = 8;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          uncached = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_data_in = '0;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] bus_data_out;
    logic          bus_data_oe;
    logic          ack_drive;
    logic          preempt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference store
    bit            m_valid [DEPTH];
    logic [AW-IW-1:0] m_tag [DEPTH];
    logic [DW-1:0] m_data [DEPTH];

    always #5 clk = ~clk;

    snoop_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW)) u_snoop_wt_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush), .uncached(uncached),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_data_in(bus_data_in), .mem_ack(mem_ack),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .ack_drive(ack_drive), .preempt(preempt)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // R9: preempt and enable follow ack on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9", "preempt", {31'b0, preempt}, {31'b0, ack_drive});
            chk("R9", "oe", {31'b0, bus_data_oe}, {31'b0, ack_drive});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit model_hit(input logic [AW-1:0] a);
        int idx;
        idx = int'(a[IW-1:0]);
        return m_valid[idx] && (m_tag[idx] == a[AW-1:IW]);
    endfunction

    task automatic read_cycle(input logic [AW-1:0] a, input bit unc, input int lat,
                              input logic [DW-1:0] md, input string req);
        int idx;
        bit h;
        idx = int'(a[IW-1:0]);
        h = model_hit(a) && !unc;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; uncached = unc;
        @(negedge clk);
        chk(req, "ack", {31'b0, ack_drive}, {31'b0, h});
        if (h) begin
            chk(req, "hit data", bus_data_out, m_data[idx]);
            bus_rd = 1'b0;
            @(negedge clk);
            chk("R10", "ack after read drop", {31'b0, ack_drive}, 32'd0);
        end else begin
            chk(req, "idle data", bus_data_out, 32'd0);
            for (int i = 1; i < lat; i++) begin
                @(negedge clk);
                chk(req, "ack wait", {31'b0, ack_drive}, 32'd0);
            end
            mem_ack = 1'b1; bus_data_in = md;
            @(negedge clk);
            mem_ack = 1'b0; bus_rd = 1'b0;
            if (!unc) begin
                m_valid[idx] = 1'b1; m_tag[idx] = a[AW-1:IW]; m_data[idx] = md;
            end
            chk(req, "ack at end", {31'b0, ack_drive}, 32'd0);
        end
        uncached = 1'b0;
    endtask

    task automatic write_cycle(input logic [AW-1:0] a, input bit unc, input int lat,
                               input logic [DW-1:0] d, input string req);
        int idx;
        idx = int'(a[IW-1:0]);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; uncached = unc; bus_data_in = d;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(req, "no ack on write", {31'b0, ack_drive}, 32'd0);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0; bus_wr = 1'b0; uncached = 1'b0;
        chk(req, "no ack on write end", {31'b0, ack_drive}, 32'd0);
        if (!unc) begin
            m_valid[idx] = 1'b1; m_tag[idx] = a[AW-1:IW]; m_data[idx] = d;
        end else if (model_hit(a)) begin
            m_valid[idx] = 1'b0;
        end
    endtask

    task automatic flush_all();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
    endtask

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1", "ack in reset", {31'b0, ack_drive}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "oe after reset", {31'b0, bus_data_oe}, 32'd0);
        chk("R1", "data after reset", bus_data_out, 32'd0);

        // R1 then R3: cold miss fills, second read hits
        read_cycle(30'h0000_0105, 1'b0, 3, 32'hCAFE_0001, "R1");
        read_cycle(30'h0000_0105, 1'b0, 3, 32'h0, "R3");
        read_cycle(30'h0000_0105, 1'b0, 3, 32'h0, "R2");

        // R5: same index, other tag
        read_cycle(30'h00AB_C105, 1'b0, 2, 32'hBEEF_0002, "R5");
        read_cycle(30'h00AB_C105, 1'b0, 2, 32'h0, "R5");
        read_cycle(30'h0000_0105, 1'b0, 1, 32'hCAFE_0003, "R5");
        read_cycle(30'h00AB_C105, 1'b0, 1, 32'hBEEF_0004, "R5");

        // R4: write-through updates
        write_cycle(30'h0002_0033, 1'b0, 2, 32'h1111_2222, "R4");
        read_cycle(30'h0002_0033, 1'b0, 2, 32'h0, "R4");
        write_cycle(30'h0002_0033, 1'b0, 1, 32'h3333_4444, "R4");
        read_cycle(30'h0002_0033, 1'b0, 2, 32'h0, "R4");

        // R7: uncached read neither hits nor fills
        read_cycle(30'h0002_0033, 1'b1, 2, 32'hDEAD_0000, "R7");
        read_cycle(30'h0002_0033, 1'b0, 2, 32'h0, "R7");
        read_cycle(30'h0001_0077, 1'b1, 2, 32'hDEAD_0001, "R7");
        read_cycle(30'h0001_0077, 1'b0, 2, 32'h5555_0001, "R7");

        // R8: uncached write invalidates a matching entry
        write_cycle(30'h0002_0033, 1'b1, 1, 32'h9999_9999, "R8");
        read_cycle(30'h0002_0033, 1'b0, 2, 32'h6666_0001, "R8");
        write_cycle(30'h0009_0033, 1'b1, 1, 32'h7777_7777, "R8");
        read_cycle(30'h0002_0033, 1'b0, 2, 32'h0, "R8");

        // R11: aborted miss stores nothing
        @(negedge clk);
        bus_addr = 30'h0000_0044; bus_rd = 1'b1; bus_data_in = 32'hABAB_ABAB;
        repeat (2) begin
            @(negedge clk);
            chk("R11", "ack during abort", {31'b0, ack_drive}, 32'd0);
        end
        bus_rd = 1'b0;
        @(negedge clk);
        read_cycle(30'h0000_0044, 1'b0, 1, 32'h4444_0044, "R11");

        // R6: flush invalidates all
        read_cycle(30'h0000_0044, 1'b0, 1, 32'h0, "R6");
        flush_all();
        read_cycle(30'h0000_0044, 1'b0, 1, 32'h4444_0045, "R6");
        read_cycle(30'h0000_0105, 1'b0, 1, 32'hCAFE_0005, "R6");

        // Mixed traffic over a few colliding addresses
        lcg = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            int op;
            bit unc;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            op  = int'(lcg[31:28]);
            unc = (lcg[27:25] == 3'd0);
            a   = {20'h0, lcg[24:23], IW'(lcg[22:21] * 8'd37)};
            if (op < 9)
                read_cycle(a, unc, 1 + int'(lcg[3:2]), lcg ^ 32'h5A5A_0000, "R2");
            else if (op < 15)
                write_cycle(a, unc, 1 + int'(lcg[5:4]), lcg ^ 32'h0F0F_F0F0, "R4");
            else
                flush_all();
        end

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule